// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous valid/ready request port to an asynchronous static RAM of 131,072 sixteen-bit words. Each accepted request carries a 17-bit word address, a direction flag, sixteen bits of write data and a two-bit lane mask. The controller then runs one complete memory cycle on the active-low strobes (chip select, output enable, write strobe and one enable per byte lane). It drives the shared data bus through a separate output-enable signal, so the pad ring builds the actual tristate.

Every analog timing figure is a parameter in picoseconds. Each is converted to a whole number of system clock cycles, rounded up, using a clock-period parameter. A write is timed from the strobe edge that ends it: the pulse must be long enough for the data setup before the rising edge. The bus is not driven until the memory's output drivers have had time to turn off after output enable rises. Read data comes back with a one-cycle valid pulse. A new request may be accepted in the last cycle of the current one, so back-to-back traffic runs at exactly the minimum cycle time.

Top module: `sram_bridge`

## Requirements
- R1: While reset is held and on the first cycle after it, chip select, output enable, write strobe and both lane enables are high, the bus output enable is low, the response valid is low and the request ready is high.
- R2: A write holds the write strobe low for exactly WE cycles, where WE = max(ceil(pulse), HZ + SD). HZ is ceil of the larger of the two output turn-off times and SD is ceil of the data setup time. Chip select is low whenever the write strobe is low.
- R3: The bus output enable is low for the first HZ cycles of the write strobe low phase. It is high for the rest of that phase and for the first cycle after the strobe rises. It is never high while output enable is low.
- R4: Lane enable bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. A lane enable is low during a cycle only if the matching mask bit is 1. A lane whose mask bit is 0 keeps its stored contents on a write.
- R5: A read starts with one cycle in which chip select is low, output enable is high and the bus is released. This is followed by exactly ACC cycles with output enable low and the write strobe high, where ACC = max(ceil(access) - 1, ceil(oe access), ceil(read cycle) - 1, 1).
- R6: The response valid is a single-cycle pulse, 2 + ACC cycles after the clock edge that accepted the read. Response data lanes whose mask bit is 0 read as zero.
- R7: Request ready is low while a cycle is in progress, except in its last cycle. Accepted requests are spaced exactly WE + END cycles apart after a write and 1 + ACC cycles apart after a read, when the next request is already waiting. END = max(1, ceil(write cycle) - WE).
- R8: The memory address stays constant for the whole write strobe low phase and equals the request address.
- R9: A read returns, in its enabled lanes, the most recent data written to that address in each lane.
- R10: A write with mask 00 leaves the memory unchanged, and a read with mask 00 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rspValid | output | 1 | Read data valid pulse |
| rspData | output | 16 | Read data, disabled lanes zero |
| memAddr | output | 17 | Memory address |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write strobe, active low |
| memBeN | output | 2 | Lane enables, active low, bit 0 = low byte |
| memDqOut | output | 16 | Data to the memory |
| memDqOe | output | 1 | Drive memDqOut onto the bus |
| memDqIn | input | 16 | Data from the bus |

## Verification
The bench keeps the 10 ns clock period but raises the write-strobe turn-off time to 17 ns, the write cycle to 45 ns and the access time to 32 ns. These values give HZ = 2, WE = 3, END = 2 and ACC = 3. With them, the turnaround alone sets the pulse length, the write needs padding after the strobe rises, and a read has several access cycles. None of these cases appears at the fastest-grade defaults, where every count is 1 or 2.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_PULSE,
    ST_WR_END,
    ST_RD_SETUP,
    ST_RD_ACC
  } phase_t;

  typedef struct packed {
    logic load;     // take the request into the hold register
    logic sel;      // chip select active
    logic rdOe;     // output enable active
    logic wrStb;    // write strobe active
    logic drive;    // controller owns the data bus
    logic capture;  // last access cycle of a read
  } ctlStb_t;

  function automatic int toCycles(input int ps, input int clkPs);
    return (ps + clkPs - 1) / clkPs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_bridge_ctl.sv
module sram_bridge_ctl
  import sram_bridge_pkg::*;
#(
  parameter int CLK_PS   = 10000,
  parameter int WP_PS    = 12000,
  parameter int DSU_PS   = 8000,
  parameter int WHZ_PS   = 7000,
  parameter int OHZ_PS   = 7000,
  parameter int WCYC_PS  = 15000,
  parameter int ACC_PS   = 15000,
  parameter int OEACC_PS = 7000,
  parameter int RCYC_PS  = 15000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output ctlStb_t stb
);

  localparam int HZ_CYC  = maxOf(toCycles(WHZ_PS, CLK_PS), toCycles(OHZ_PS, CLK_PS));
  localparam int SD_CYC  = maxOf(toCycles(DSU_PS, CLK_PS), 1);
  localparam int WE_CYC  = maxOf(maxOf(toCycles(WP_PS, CLK_PS), 1), HZ_CYC + SD_CYC);
  localparam int END_CYC = maxOf(1, toCycles(WCYC_PS, CLK_PS) - WE_CYC);
  localparam int ACC_CYC = maxOf(maxOf(toCycles(ACC_PS, CLK_PS) - 1, toCycles(OEACC_PS, CLK_PS)),
                                 maxOf(toCycles(RCYC_PS, CLK_PS) - 1, 1));
  localparam int CNT_W   = $clog2(maxOf(maxOf(WE_CYC, END_CYC), ACC_CYC) + 1);

  localparam logic [CNT_W-1:0] WE_LAST  = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] END_LAST = CNT_W'(END_CYC - 1);
  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_CNT   = CNT_W'(HZ_CYC);

  phase_t           state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             opLast;
  logic             accept;

  always_comb begin
    opLast   = ((state == ST_WR_END) && (cnt == END_LAST)) ||
               ((state == ST_RD_ACC) && (cnt == ACC_LAST));
    reqReady = (state == ST_IDLE) || opLast;
    accept   = reqValid && reqReady;
  end

  always_comb begin
    nextState = state;
    nextCnt   = cnt + CNT_W'(1);
    unique case (state)
      ST_WR_PULSE: begin
        if (cnt == WE_LAST) begin
          nextState = ST_WR_END;
          nextCnt   = '0;
        end
      end
      ST_RD_SETUP: begin
        nextState = ST_RD_ACC;
        nextCnt   = '0;
      end
      default: begin
        nextCnt = (state == ST_IDLE) ? '0 : cnt + CNT_W'(1);
        if (state == ST_IDLE || opLast) begin
          nextCnt   = '0;
          nextState = accept ? (reqWrite ? ST_WR_PULSE : ST_RD_SETUP) : ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  always_comb begin
    stb.load    = accept;
    stb.sel     = (state != ST_IDLE);
    stb.rdOe    = (state == ST_RD_ACC);
    stb.wrStb   = (state == ST_WR_PULSE);
    stb.drive   = ((state == ST_WR_PULSE) && (cnt >= HZ_CNT)) || (state == ST_WR_END);
    stb.capture = (state == ST_RD_ACC) && (cnt == ACC_LAST);
  end

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WR_PULSE || state == ST_RD_SETUP) |-> !reqReady);

  // R5
  setup_then_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_SETUP) |=> (state == ST_RD_ACC));

endmodule

// File: rtl/sram_bridge_dp.sv
module sram_bridge_dp
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStb_t               stb,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqMask,
  output logic                  rspValid,
  output logic [DATA_W-1:0]     rspData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memCeN,
  output logic                  memOeN,
  output logic                  memWeN,
  output logic [DATA_W/8-1:0]   memBeN,
  output logic [DATA_W-1:0]     memDqOut,
  output logic                  memDqOe,
  input  logic [DATA_W-1:0]     memDqIn
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] holdAddr;
  logic [DATA_W-1:0] holdData;
  logic [LANES-1:0]  holdMask;
  logic [LANES-1:0]  beNext;
  logic [DATA_W-1:0] laneData;
  logic              capD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdAddr <= '0;
      holdData <= '0;
      holdMask <= '0;
    end else if (stb.load) begin
      holdAddr <= reqAddr;
      holdData <= reqWdata;
      holdMask <= reqMask;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign beNext[i]         = !(stb.sel && holdMask[i]);
    assign laneData[8*i +: 8] = memBeN[i] ? 8'h00 : memDqIn[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCeN   <= 1'b1;
      memOeN   <= 1'b1;
      memWeN   <= 1'b1;
      memBeN   <= '1;
      memDqOe  <= 1'b0;
      memAddr  <= '0;
      memDqOut <= '0;
      capD     <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      memCeN   <= !stb.sel;
      memOeN   <= !stb.rdOe;
      memWeN   <= !stb.wrStb;
      memBeN   <= beNext;
      memDqOe  <= stb.drive;
      memAddr  <= holdAddr;
      memDqOut <= holdData;
      capD     <= stb.capture;
      rspValid <= capD;
      if (capD) rspData <= laneData;
    end
  end

  // R2
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN);

  // R5
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCeN));

  // R3
  no_contend_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDqOe);

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWeN && $past(!memWeN)) |-> (memDqOe && !memCeN));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memAddr));

  // R6
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int CLK_PS   = 10000,
  parameter int WP_PS    = 12000,
  parameter int DSU_PS   = 8000,
  parameter int WHZ_PS   = 7000,
  parameter int OHZ_PS   = 7000,
  parameter int WCYC_PS  = 15000,
  parameter int ACC_PS   = 15000,
  parameter int OEACC_PS = 7000,
  parameter int RCYC_PS  = 15000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCeN,
  output logic                memOeN,
  output logic                memWeN,
  output logic [DATA_W/8-1:0] memBeN,
  output logic [DATA_W-1:0]   memDqOut,
  output logic                memDqOe,
  input  logic [DATA_W-1:0]   memDqIn
);

  ctlStb_t stb;

  sram_bridge_ctl #(
    .CLK_PS(CLK_PS), .WP_PS(WP_PS), .DSU_PS(DSU_PS), .WHZ_PS(WHZ_PS),
    .OHZ_PS(OHZ_PS), .WCYC_PS(WCYC_PS), .ACC_PS(ACC_PS),
    .OEACC_PS(OEACC_PS), .RCYC_PS(RCYC_PS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  sram_bridge_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memBeN(memBeN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

endmodule

// File: tb/tb_sram_bridge.sv
module tb_sram_bridge;

  localparam int CLK_PS   = 10000;
  localparam int WP_PS    = 12000;
  localparam int DSU_PS   = 8000;
  localparam int WHZ_PS   = 17000;
  localparam int OHZ_PS   = 7000;
  localparam int WCYC_PS  = 45000;
  localparam int ACC_PS   = 32000;
  localparam int OEACC_PS = 7000;
  localparam int RCYC_PS  = 15000;

  function automatic int cdiv(input int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_HZ   = mx(cdiv(WHZ_PS), cdiv(OHZ_PS));
  localparam int E_SD   = mx(cdiv(DSU_PS), 1);
  localparam int E_WE   = mx(mx(cdiv(WP_PS), 1), E_HZ + E_SD);
  localparam int E_END  = mx(1, cdiv(WCYC_PS) - E_WE);
  localparam int E_ACC  = mx(mx(cdiv(ACC_PS) - 1, cdiv(OEACC_PS)), mx(cdiv(RCYC_PS) - 1, 1));
  localparam int E_WTOT = E_WE + E_END;
  localparam int E_RTOT = 1 + E_ACC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        reqReady, rspValid, memCeN, memOeN, memWeN, memDqOe;
  logic [15:0] rspData, memDqOut;
  logic [15:0] memDqIn = '0;
  logic [16:0] memAddr;
  logic [1:0]  memBeN;

  sram_bridge #(
    .CLK_PS(CLK_PS), .WP_PS(WP_PS), .DSU_PS(DSU_PS), .WHZ_PS(WHZ_PS),
    .OHZ_PS(OHZ_PS), .WCYC_PS(WCYC_PS), .ACC_PS(ACC_PS),
    .OEACC_PS(OEACC_PS), .RCYC_PS(RCYC_PS)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .memBeN(memBeN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  nChk = 0, nBad = 0;
  bit  finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] initPat(input int a);
    return 16'(a * 40503) ^ 16'h5A3C;
  endfunction

  // memory model driven by the pins, and a shadow built from requests
  logic [15:0] mdl [int];
  logic [15:0] shd [int];

  function automatic logic [15:0] mdlWord(input int a);
    return mdl.exists(a) ? mdl[a] : initPat(a);
  endfunction
  function automatic logic [15:0] shdWord(input int a);
    return shd.exists(a) ? shd[a] : initPat(a);
  endfunction

  int          weLowLen = 0, oeLowLen = 0;
  bit          prevSetup = 0;
  logic [16:0] lastAddr;
  logic [15:0] lastData;
  logic [1:0]  lastBeN;
  int          qCyc[$];
  logic [15:0] qDat[$];

  always @(negedge clk) begin
    if (rstN) begin
      // write strobe tracking (R2, R3, R8, R4)
      if (!memWeN) begin
        check(!memCeN, "R2", "chip select during write strobe", memCeN, 0);
        if (weLowLen < E_HZ)
          check(!memDqOe, "R3", "bus driven inside turnaround", memDqOe, 0);
        else
          check(memDqOe, "R3", "bus not driven before write end", memDqOe, 1);
        if (weLowLen > 0)
          check(memAddr == lastAddr, "R8", "address moved in write", memAddr, lastAddr);
        weLowLen++;
        lastAddr = memAddr;
        lastData = memDqOut;
        lastBeN  = memBeN;
      end else if (weLowLen > 0) begin
        check(weLowLen == E_WE, "R2", "write strobe length", weLowLen, E_WE);
        check(memDqOe && !memCeN, "R3", "data hold after strobe rise", memDqOe, 1);
        for (int i = 0; i < 2; i++) begin
          if (!lastBeN[i]) begin
            logic [15:0] w;
            w = mdlWord(int'(lastAddr));
            w[8*i +: 8] = lastData[8*i +: 8];
            mdl[int'(lastAddr)] = w;
          end
        end
        weLowLen = 0;
      end
      // contention and read phases (R3, R5)
      if (!memCeN && !memOeN && memWeN && memDqOe)
        check(0, "R3", "bus contention during read", 1, 0);
      if (!memOeN) begin
        if (oeLowLen == 0)
          check(prevSetup, "R5", "read setup cycle missing", prevSetup, 1);
        oeLowLen++;
      end else if (oeLowLen > 0) begin
        check(oeLowLen == E_ACC, "R5", "output enable length", oeLowLen, E_ACC);
        oeLowLen = 0;
      end
      prevSetup = !memCeN && memOeN && memWeN && !memDqOe;
      // memory drives the bus in a read
      if (!memCeN && !memOeN && memWeN) begin
        memDqIn = mdlWord(int'(memAddr));
        for (int i = 0; i < 2; i++)
          if (memBeN[i]) memDqIn[8*i +: 8] = 8'hEE;
      end else begin
        memDqIn = 16'h0000;
      end
      // responses (R6, R9, R4, R10)
      if (rspValid) begin
        if (qCyc.size() == 0) begin
          check(0, "R6", "unexpected response", 1, 0);
        end else begin
          check(qCyc[0] == cyc, "R6", "response cycle", cyc, qCyc[0]);
          check(rspData == qDat[0], "R9", "read data", rspData, qDat[0]);
          void'(qCyc.pop_front());
          void'(qDat.pop_front());
        end
      end else if (qCyc.size() > 0 && qCyc[0] <= cyc) begin
        check(0, "R6", "missing response", 0, 1);
        void'(qCyc.pop_front());
        void'(qDat.pop_front());
      end
    end
  end

  int lastAcc = -1;
  int lastTot = 0;

  task automatic issue(input bit w, input int a, input logic [15:0] d,
                       input logic [1:0] m, input int gap);
    bit waited;
    int accCyc;
    logic [15:0] e;
    repeat (gap) @(negedge clk);
    reqValid = 1'b1;
    reqWrite = w;
    reqAddr  = 17'(a);
    reqWdata = d;
    reqMask  = m;
    waited = 0;
    while (!reqReady) begin
      waited = 1;
      @(negedge clk);
    end
    accCyc = cyc + 1;
    if (lastAcc >= 0) begin
      if (waited)
        check(accCyc - lastAcc == lastTot, "R7", "back-to-back spacing", accCyc - lastAcc, lastTot);
      else
        check(accCyc - lastAcc >= lastTot, "R7", "minimum spacing", accCyc - lastAcc, lastTot);
    end
    lastAcc = accCyc;
    lastTot = w ? E_WTOT : E_RTOT;
    if (w) begin
      e = shdWord(a);
      for (int i = 0; i < 2; i++)
        if (m[i]) e[8*i +: 8] = d[8*i +: 8];
      shd[a] = e;
    end else begin
      e = shdWord(a);
      for (int i = 0; i < 2; i++)
        if (!m[i]) e[8*i +: 8] = 8'h00;
      qCyc.push_back(accCyc + 2 + E_ACC);
      qDat.push_back(e);
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    check(0, "R7", "watchdog expired", cyc, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd7177));
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check(memCeN && memOeN && memWeN && memBeN == 2'b11, "R1", "strobes in reset",
          {memCeN, memOeN, memWeN, memBeN}, 5'h1F);
    check(!memDqOe && !rspValid, "R1", "bus and response in reset", {memDqOe, rspValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(memCeN && memOeN && memWeN && memBeN == 2'b11 && !memDqOe, "R1",
          "strobes after reset", {memCeN, memOeN, memWeN, memBeN, memDqOe}, 6'h3E);
    check(reqReady && !rspValid, "R1", "ready after reset", {reqReady, rspValid}, 2'b10);

    // R9: full word write then read
    issue(1, 0, 16'h1234, 2'b11, 0);
    issue(0, 0, 16'h0, 2'b11, 0);
    // R4: low lane only at top address, high lane keeps initial value
    issue(1, 17'h1FFFF, 16'hABCD, 2'b01, 0);
    issue(0, 17'h1FFFF, 16'h0, 2'b11, 0);
    // R4: high lane only
    issue(1, 9, 16'h77AA, 2'b10, 1);
    issue(0, 9, 16'h0, 2'b11, 0);
    // R10: empty mask write and read
    issue(1, 5, 16'hFFFF, 2'b00, 0);
    issue(0, 5, 16'h0, 2'b11, 0);
    issue(0, 0, 16'h0, 2'b00, 0);
    // R6: partial lane reads
    issue(0, 0, 16'h0, 2'b01, 2);
    issue(0, 0, 16'h0, 2'b10, 0);
    // R7: write/write, write/read, read/read, read/write back to back
    issue(1, 1, 16'h1111, 2'b11, 0);
    issue(1, 2, 16'h2222, 2'b11, 0);
    issue(0, 1, 16'h0, 2'b11, 0);
    issue(0, 2, 16'h0, 2'b11, 0);
    issue(1, 1, 16'h3333, 2'b11, 0);
    issue(0, 1, 16'h0, 2'b11, 0);

    for (int n = 0; n < 400; n++) begin
      int a, g;
      a = ($urandom % 16 == 0) ? 17'h1FFFF : int'($urandom % 24);
      g = ($urandom % 4 == 0) ? int'($urandom % 3) : 0;
      issue(bit'($urandom % 2), a, 16'($urandom), 2'($urandom), g);
    end

    repeat (E_RTOT + 10) @(negedge clk);
    check(qCyc.size() == 0, "R6", "responses outstanding", qCyc.size(), 0);
    finishRun();
  end

endmodule